// File: doc/BRIEF.md
# CAN Transceiver Mode and Transmit-Protection Controller

This block is the digital control core of a high-speed CAN FD line transceiver. It takes the transmit-data line and the silent-select line from the protocol controller, plus digital flags for core-supply undervoltage, I/O-supply undervoltage and over-temperature. From these it chooses one of three operating modes (power-off, normal, silent) and decides when the bus driver may actually pull the bus dominant.

Three independent lockouts guard the driver. The first is a dominant-timeout timer that stops a stuck-low transmit line from blocking the network. The second is a thermal lockout. The third is a lockout held after supply recovery. Each lockout releases only once the transmit line has been seen high again. The receive line mirrors the bus comparator in every powered mode and is tri-stated in power-off. The timeout and the silent-to-normal delay are parameters counted in clock cycles. Both transmit data and silent select pass through a two-flop synchronizer whose reset value is high, because both lines are pulled up.

Top module: `can_xcvr_ctrl`

## Requirements
- R1: While either undervoltage flag is high, the block is in power-off mode one clock later (mode_o = 2'b00). In power-off, bias_en_o, rxd_oe_o, tx_en_o and drive_dom_o are all 0, and the timeout state is cleared.
- R2: When both undervoltage flags are low in power-off, the block leaves power-off on the next clock. It enters silent mode (mode_o = 2'b10) if the synchronized select is high, and normal mode (mode_o = 2'b01) otherwise.
- R3: In normal mode with no lockout, drive_dom_o equals the inverse of txd_i delayed by the two-flop synchronizer. While rxd_oe_o is 1, rxd_o equals the inverse of bus_dom_i.
- R4: In silent mode, drive_dom_o and tx_en_o stay 0 whatever txd_i does, while rxd_o still follows the bus and rxd_oe_o and bias_en_o are 1.
- R5: If the synchronized transmit line stays low for TO_CYC cycles, lock_timeout_o rises, and tx_en_o and drive_dom_o fall. The lock holds while the line stays low and clears on its first high sample.
- R6: The over-temperature flag sets lock_thermal_o and blocks transmission, while the receive path and the mode are unchanged. The lock clears only in a cycle where the flag is low and the synchronized transmit line is high.
- R7: lock_uv_o is 1 out of reset and during any undervoltage. After supply recovery it stays 1, and no dominant is driven, until the synchronized transmit line is seen high.
- R8: A change from normal to silent takes effect one clock after the synchronized select goes high. A change from silent to normal takes effect MODE_DLY clocks after the synchronized select goes low, and is abandoned if the select rises again first.
- R9: During reset, mode_o is 2'b00, lock_uv_o is 1, and tx_en_o, bias_en_o, rxd_oe_o and drive_dom_o are 0.
- R10: tx_en_o is 1 exactly when the mode is normal and none of the timeout, thermal or undervoltage lockouts is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Control clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| txd_i | input | 1 | Transmit data from controller, 0 = dominant |
| silent_i | input | 1 | Silent-mode select, 1 = listen only |
| uv_core_i | input | 1 | Core supply undervoltage flag |
| uv_io_i | input | 1 | I/O supply undervoltage flag |
| overtemp_i | input | 1 | Over-temperature flag |
| bus_dom_i | input | 1 | Bus comparator, 1 = bus dominant |
| tx_en_o | output | 1 | Transmitter permitted |
| drive_dom_o | output | 1 | Drive bus dominant now |
| bias_en_o | output | 1 | Bus biasing enabled |
| rxd_o | output | 1 | Receive data, 0 = bus dominant |
| rxd_oe_o | output | 1 | Receive data output enable |
| mode_o | output | 2 | 00 power-off, 01 normal, 10 silent |
| lock_timeout_o | output | 1 | Dominant-timeout lockout active |
| lock_thermal_o | output | 1 | Thermal lockout active |
| lock_uv_o | output | 1 | Post-undervoltage lockout active |

## Verification
A wrong mode register shows at once on mode_o, bias_en_o and rxd_oe_o, one clock after the flag or the synchronized select that should have moved it. A lockout that is set or cleared at the wrong moment shows on its status output and on tx_en_o within one cycle. A timer that counts wrongly shows as lock_timeout_o rising before or well after TO_CYC cycles of low transmit data. The bench brackets each transition between a sample just before its expected cycle and one just after, so an off-by-several error in either counter is caught.

// File: rtl/can_ctrl_pkg.sv
package can_ctrl_pkg;
  typedef enum logic [1:0] {
    MODE_OFF    = 2'b00,
    MODE_NORMAL = 2'b01,
    MODE_SILENT = 2'b10
  } mode_e;
endpackage

// File: rtl/can_sync.sv
module can_sync #(
  parameter int unsigned W       = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= RST_VAL[g];
        s2_q <= RST_VAL[g];
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
      end
    end
    assign q_o[g] = s2_q;
  end
endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
  import can_ctrl_pkg::*;
#(
  parameter int unsigned MODE_DLY = 2000
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  uv_i,
  input  logic  sel_i,
  output mode_e mode_o
);
  localparam int unsigned CW = $clog2(MODE_DLY + 1);
  localparam logic [CW-1:0] LAST = CW'(MODE_DLY - 1);

  mode_e         mode_q;
  logic [CW-1:0] dly_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_OFF;
      dly_q  <= '0;
    end else if (uv_i) begin
      mode_q <= MODE_OFF;
      dly_q  <= '0;
    end else begin
      case (mode_q)
        MODE_OFF: begin
          mode_q <= sel_i ? MODE_SILENT : MODE_NORMAL;
          dly_q  <= '0;
        end
        MODE_NORMAL: begin
          if (sel_i) mode_q <= MODE_SILENT;
          dly_q <= '0;
        end
        MODE_SILENT: begin
          if (sel_i) begin
            dly_q <= '0;
          end else if (dly_q == LAST) begin
            mode_q <= MODE_NORMAL;
            dly_q  <= '0;
          end else begin
            dly_q <= dly_q + 1'b1;
          end
        end
        default: begin
          mode_q <= MODE_OFF;
          dly_q  <= '0;
        end
      endcase
    end
  end

  assign mode_o = mode_q;

  a_r1_uv_forces_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv_i |=> mode_q == MODE_OFF);
  a_r2_leave_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_OFF && !uv_i) |=> mode_q != MODE_OFF);
  a_r8_to_silent_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_NORMAL && sel_i && !uv_i) |=> mode_q == MODE_SILENT);
  a_r8_hold_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_SILENT && sel_i && !uv_i) |=> mode_q == MODE_SILENT);
endmodule

// File: rtl/can_dom_timer.sv
module can_dom_timer #(
  parameter int unsigned TO_CYC = 200000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic txd_i,
  output logic lock_o
);
  localparam int unsigned CW = $clog2(TO_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(TO_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          lock_q;

  // Synchronizer resets high, so counting from the first low sample is
  // the same as starting on a falling edge; a rising edge clears all.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else if (clr_i || txd_i) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      if (cnt_q == LAST) lock_q <= 1'b1;
      if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign lock_o = lock_q;

  a_r5_lock_holds_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && !txd_i && !clr_i) |=> lock_q);
  a_r5_release_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txd_i |=> !lock_q);
  a_r1_uv_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!lock_q && cnt_q == '0));
endmodule

// File: rtl/can_tx_lockout.sv
module can_tx_lockout (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic uv_i,
  input  logic ot_i,
  input  logic txd_i,
  output logic lock_th_o,
  output logic lock_uv_o
);
  logic lock_th_q, lock_uv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_th_q <= 1'b0;
      lock_uv_q <= 1'b1;
    end else begin
      lock_th_q <= ot_i | (lock_th_q & ~txd_i);
      lock_uv_q <= uv_i | (lock_uv_q & ~txd_i);
    end
  end

  assign lock_th_o = lock_th_q;
  assign lock_uv_o = lock_uv_q;

  a_r6_thermal_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ot_i |=> lock_th_q);
  a_r6_thermal_needs_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_th_q && !txd_i) |=> lock_th_q);
  a_r7_uv_needs_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_uv_q && !txd_i) |=> lock_uv_q);
endmodule

// File: rtl/can_xcvr_ctrl.sv
module can_xcvr_ctrl
  import can_ctrl_pkg::*;
#(
  parameter int unsigned TO_CYC   = 200000,
  parameter int unsigned MODE_DLY = 2000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       txd_i,
  input  logic       silent_i,
  input  logic       uv_core_i,
  input  logic       uv_io_i,
  input  logic       overtemp_i,
  input  logic       bus_dom_i,
  output logic       tx_en_o,
  output logic       drive_dom_o,
  output logic       bias_en_o,
  output logic       rxd_o,
  output logic       rxd_oe_o,
  output logic [1:0] mode_o,
  output logic       lock_timeout_o,
  output logic       lock_thermal_o,
  output logic       lock_uv_o
);
  logic [1:0] sync_q;
  logic       txd_s, sel_s, uv_any;
  logic       lock_to, lock_th, lock_uv;
  mode_e      mode;

  assign uv_any = uv_core_i | uv_io_i;

  can_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({silent_i, txd_i}),
    .q_o   (sync_q)
  );
  assign txd_s = sync_q[0];
  assign sel_s = sync_q[1];

  can_mode_seq #(.MODE_DLY(MODE_DLY)) u_mode (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .uv_i  (uv_any),
    .sel_i (sel_s),
    .mode_o(mode)
  );

  can_dom_timer #(.TO_CYC(TO_CYC)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (uv_any),
    .txd_i (txd_s),
    .lock_o(lock_to)
  );

  can_tx_lockout u_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .uv_i     (uv_any),
    .ot_i     (overtemp_i),
    .txd_i    (txd_s),
    .lock_th_o(lock_th),
    .lock_uv_o(lock_uv)
  );

  assign tx_en_o        = (mode == MODE_NORMAL) & ~lock_to & ~lock_th & ~lock_uv;
  assign drive_dom_o    = tx_en_o & ~txd_s;
  assign bias_en_o      = (mode != MODE_OFF);
  assign rxd_oe_o       = (mode != MODE_OFF);
  assign rxd_o          = rxd_oe_o ? ~bus_dom_i : 1'b1;
  assign mode_o         = mode;
  assign lock_timeout_o = lock_to;
  assign lock_thermal_o = lock_th;
  assign lock_uv_o      = lock_uv;

  a_r4_silent_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_SILENT) |-> !drive_dom_o);
  a_r10_drive_needs_lowtx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_dom_o |-> (!txd_s && !lock_uv && !lock_th && !lock_to));
  a_r1_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_OFF) |-> (!rxd_oe_o && !bias_en_o && !tx_en_o));
endmodule

// File: tb/sim_can_xcvr_ctrl.sv
`timescale 1ns/1ps
module sim_can_xcvr_ctrl;
  localparam int TO_CYC   = 40;
  localparam int MODE_DLY = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic txd_i = 1'b1, silent_i = 1'b0, uv_core_i = 1'b0, uv_io_i = 1'b0;
  logic overtemp_i = 1'b0, bus_dom_i = 1'b0;
  logic tx_en_o, drive_dom_o, bias_en_o, rxd_o, rxd_oe_o;
  logic [1:0] mode_o;
  logic lock_timeout_o, lock_thermal_o, lock_uv_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  can_xcvr_ctrl #(.TO_CYC(TO_CYC), .MODE_DLY(MODE_DLY)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .txd_i(txd_i), .silent_i(silent_i),
    .uv_core_i(uv_core_i), .uv_io_i(uv_io_i), .overtemp_i(overtemp_i),
    .bus_dom_i(bus_dom_i), .tx_en_o(tx_en_o), .drive_dom_o(drive_dom_o),
    .bias_en_o(bias_en_o), .rxd_o(rxd_o), .rxd_oe_o(rxd_oe_o), .mode_o(mode_o),
    .lock_timeout_o(lock_timeout_o), .lock_thermal_o(lock_thermal_o),
    .lock_uv_o(lock_uv_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #1;
    step(3);
    // R9 reset state
    chk("R9 mode", mode_o, 0);
    chk("R9 lock_uv", lock_uv_o, 1);
    chk("R9 tx_en", tx_en_o, 0);
    chk("R9 bias", bias_en_o, 0);
    chk("R9 oe", rxd_oe_o, 0);
    chk("R9 drive", drive_dom_o, 0);
    rst_ni = 1'b1;
    step(2 + MODE_DLY + 6);
    chk("R2 normal after reset", mode_o, 1);
    chk("R10 tx_en all clear", tx_en_o, 1);

    // R3 normal mode sweep
    for (int t = 0; t < 2; t++) begin
      for (int b = 0; b < 2; b++) begin
        txd_i = t[0]; bus_dom_i = b[0];
        step(3);
        chk("R3 drive", drive_dom_o, 1 - t);
        chk("R3 rxd", rxd_o, 1 - b);
        chk("R3 oe", rxd_oe_o, 1);
      end
    end
    txd_i = 1'b1; bus_dom_i = 1'b0;

    // R8 normal -> silent
    silent_i = 1'b1;
    step(3);
    chk("R8 to silent", mode_o, 2);
    chk("R4 tx_en silent", tx_en_o, 0);
    for (int t = 0; t < 2; t++) begin
      for (int b = 0; b < 2; b++) begin
        txd_i = t[0]; bus_dom_i = b[0];
        step(3);
        chk("R4 drive silent", drive_dom_o, 0);
        chk("R4 rxd silent", rxd_o, 1 - b);
        chk("R4 bias silent", bias_en_o, 1);
      end
    end
    txd_i = 1'b1; bus_dom_i = 1'b0;
    step(3);

    // R8 silent -> normal delay, aborted then completed
    silent_i = 1'b0;
    step(5);
    silent_i = 1'b1;
    step(MODE_DLY + 4);
    chk("R8 abort stays silent", mode_o, 2);
    silent_i = 1'b0;
    step(MODE_DLY);
    chk("R8 still silent before delay", mode_o, 2);
    step(4);
    chk("R8 normal after delay", mode_o, 1);

    // R5 dominant timeout
    txd_i = 1'b0;
    step(TO_CYC);
    chk("R5 before timeout drive", drive_dom_o, 1);
    chk("R5 before timeout lock", lock_timeout_o, 0);
    step(4);
    chk("R5 lock set", lock_timeout_o, 1);
    chk("R5 drive off", drive_dom_o, 0);
    chk("R10 tx_en off timeout", tx_en_o, 0);
    step(20);
    chk("R5 lock held", lock_timeout_o, 1);
    txd_i = 1'b1;
    step(4);
    chk("R5 lock cleared", lock_timeout_o, 0);
    chk("R5 tx_en back", tx_en_o, 1);

    // R6 thermal
    overtemp_i = 1'b1;
    step(1);
    chk("R6 lock set", lock_thermal_o, 1);
    chk("R6 tx_en off", tx_en_o, 0);
    txd_i = 1'b0; bus_dom_i = 1'b1;
    step(3);
    chk("R6 no drive", drive_dom_o, 0);
    chk("R6 rxd works", rxd_o, 0);
    chk("R6 mode kept", mode_o, 1);
    overtemp_i = 1'b0;
    step(3);
    chk("R6 held while txd low", lock_thermal_o, 1);
    txd_i = 1'b1; bus_dom_i = 1'b0;
    step(4);
    chk("R6 cleared", lock_thermal_o, 0);
    chk("R6 tx_en back", tx_en_o, 1);

    // R1 / R7 core undervoltage
    uv_core_i = 1'b1;
    step(1);
    chk("R1 mode off", mode_o, 0);
    chk("R1 oe off", rxd_oe_o, 0);
    chk("R1 bias off", bias_en_o, 0);
    chk("R1 tx_en off", tx_en_o, 0);
    chk("R7 lock during uv", lock_uv_o, 1);
    txd_i = 1'b0;
    step(4);
    uv_core_i = 1'b0;
    step(16);
    chk("R2 normal after uv", mode_o, 1);
    chk("R7 lock held", lock_uv_o, 1);
    chk("R7 no drive", drive_dom_o, 0);
    txd_i = 1'b1;
    step(4);
    chk("R7 lock cleared", lock_uv_o, 0);
    txd_i = 1'b0;
    step(3);
    chk("R7 drive after release", drive_dom_o, 1);
    txd_i = 1'b1;
    step(3);

    // R1 / R2 io undervoltage, exit to silent
    uv_io_i = 1'b1; silent_i = 1'b1;
    step(1);
    chk("R1 io uv off", mode_o, 0);
    step(4);
    uv_io_i = 1'b0;
    step(2);
    chk("R2 silent after uv", mode_o, 2);
    chk("R2 oe back", rxd_oe_o, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule